// File: doc/BRIEF.md
# Shape Slot Allocator with Persistence

This block turns one shape command into a 32-bit matrix shape descriptor and installs it into one or more of four shape slots. A 5-bit operand mask decides which operands are remapped. For each operand the block writes a 2-bit slot selector into a state register. The command's extent sets the first dimension. The second dimension is found by counting up against the current maximum vector length. One counting step is taken per clock cycle, so the latency depends on the data.

There are two commit modes. In bulk mode (`mm`=0) all four slots and all selectors are cleared first. The shape is then handed out round-robin over the set bits of the mask, and the mask becomes the operand enable field. In refined mode (`mm`=1) the mask is read as an operand number and a slot number instead. Only that one slot and that one selector change. Everything else the earlier commands installed is left in place.

A descriptor has one of two forms. The plain form carries a 4-bit offset. The indexed form carries a register base, an element-width code and a skip flag.

Top module: `shape_slot_alloc`

## Requirements
- R1: After reset `slots`, `sel`, `en`, `persist`, `busy` and `done` are all zero.
- R2: With dim = `dim_m1`+1, the search yields d, the smallest value counted up from zero for which d*dim >= `maxvl`. `maxvl` is sampled when the command is accepted. `done` is high for exactly one cycle, d+1 clock edges after the edge that accepted `start`, and all outputs change at that same edge.
- R3: With `yx`=0, ydim in bits [11:6] is 63 when `skip`=1 and 0 when `skip`=0. The permute field [20:18] is 3'b110 in indexed form and 3'b000 in plain form.
- R4: With `yx`=1, ydim in bits [11:6] is 0 when `skip`=1 and the low six bits of d-1 when `skip`=0. The permute field [20:18] is 3'b111 in indexed form and 3'b010 in plain form.
- R5: In plain form (`form_idx`=0), bits [27:24] hold `offset` and bits [29:28] are 2'b01 when `skip`=1 and 2'b00 otherwise. Bits [17:12] and [21] are zero.
- R6: In indexed form (`form_idx`=1), bits [17:12] hold `base` zero-extended, [29:28] hold `ew` and [21] holds `skip`. Bits [27:24] are zero. In both forms, bits [5:0] hold `dim_m1` zero-extended, and bits [23:22] and the mode field [31:30] are zero.
- R7: At each commit, `persist` takes the value of `mm`.
- R8: Bulk commit (`mm`=0) visits operands k = 0 to 4 in order. Each k with `mask[k]`=1 gets the next slot number in the sequence 0,1,2,3,0. Its selector `sel[2k+1:2k]` gets that number, and that slot gets the shape. Slots that no operand receives become zero, as do the selectors of operands that are not set. `en` becomes `mask`.
- R9: Refined commit (`mm`=1) uses operand p = `mask[4:2]` and slot s = `mask[1:0]`. Slot s gets the shape. If p <= 4, `sel[2p+1:2p]` becomes s and `en[p]` is set. If p >= 5, `sel` and `en` are unchanged. The other slots, selectors and enable bits are kept.
- R10: A `start` that arrives while `busy` is high is ignored. It has no effect on the result or the timing of the command in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept a command when not busy |
| form_idx | input | 1 | 1 = indexed form, 0 = plain form |
| dim_m1 | input | 5 | First dimension minus one |
| yx | input | 1 | Dimension order select |
| skip | input | 1 | Skip first dimension |
| offset | input | 4 | Element offset (plain form) |
| base | input | 5 | Index register base (indexed form) |
| ew | input | 2 | Element-width code (indexed form) |
| mask | input | 5 | Operand mask (bulk) or operand/slot pair (refined) |
| mm | input | 1 | 0 = bulk commit, 1 = refined persistent commit |
| maxvl | input | 7 | Current maximum vector length |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse at commit |
| slots | output | 128 | Slot s at bits [32s+31:32s] |
| sel | output | 10 | Selector of operand k at [2k+1:2k] |
| en | output | 5 | Operand enable bits |
| persist | output | 1 | Last commit mode |

## Verification
The hardest case to reach is a refined commit that lands on state left by earlier commands. This is the only place where leftover slots, selectors and enable bits should survive, and where an operand number of 5 to 7 must leave `sel` and `en` alone. The stimulus strings bulk and refined commands together in random order, against a bench model that holds the state from one command to the next. A directed sequence then makes a five-bit bulk commit that wraps the slot counter, followed by refined writes to operand 6 and to operand 4. A second command started in the middle of a long search checks that a new `start` is ignored while busy.

// File: rtl/shape_slot_alloc.sv
module shape_slot_alloc #(
  parameter int DIM_W = 5,
  parameter int MVL_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               form_idx,
  input  logic [DIM_W-1:0]   dim_m1,
  input  logic               yx,
  input  logic               skip,
  input  logic [3:0]         offset,
  input  logic [4:0]         base,
  input  logic [1:0]         ew,
  input  logic [4:0]         mask,
  input  logic               mm,
  input  logic [MVL_W-1:0]   maxvl,
  output logic               busy,
  output logic               done,
  output logic [127:0]       slots,
  output logic [9:0]         sel,
  output logic [4:0]         en,
  output logic               persist
);
  localparam int NSLOT = 4;
  localparam int NOPS  = 5;
  localparam int PW    = MVL_W + DIM_W + 1;

  logic             c_idx, c_yx, c_sk, c_mm;
  logic [DIM_W-1:0] c_dim;
  logic [3:0]       c_ofs;
  logic [4:0]       c_base, c_mask;
  logic [1:0]       c_ew;
  logic [MVL_W-1:0] c_mvl, d_q;
  logic [PW-1:0]    prod_q;
  logic [31:0]      slot_q [NSLOT];

  logic [31:0] shape;
  logic [5:0]  ydim;
  logic [2:0]  perm;
  logic        more;

  assign more = prod_q < PW'(c_mvl);

  assign ydim = c_yx ? (c_sk ? 6'd0 : 6'(d_q - 1'b1)) : (c_sk ? 6'h3f : 6'd0);
  assign perm = c_idx ? {2'b11, c_yx} : {1'b0, c_yx, 1'b0};

  always_comb begin
    shape        = '0;
    shape[5:0]   = 6'(c_dim);
    shape[11:6]  = ydim;
    shape[20:18] = perm;
    if (c_idx) begin
      shape[17:12] = {1'b0, c_base};
      shape[21]    = c_sk;
      shape[29:28] = c_ew;
    end else begin
      shape[27:24] = c_ofs;
      shape[29:28] = {1'b0, c_sk};
    end
  end

  logic [1:0]       rr;
  logic [NSLOT-1:0] hit;
  logic [9:0]       bsel;

  always_comb begin
    rr   = '0;
    hit  = '0;
    bsel = '0;
    for (int k = 0; k < NOPS; k++) begin
      if (c_mask[k]) begin
        bsel[2*k +: 2] = rr;
        hit[rr]        = 1'b1;
        rr             = rr + 2'd1;
      end
    end
  end

  logic [2:0] r_op;
  logic [1:0] r_sl;
  assign r_op = c_mask[4:2];
  assign r_sl = c_mask[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      persist <= 1'b0;
      sel     <= '0;
      en      <= '0;
      d_q     <= '0;
      prod_q  <= '0;
      c_idx   <= 1'b0;
      c_yx    <= 1'b0;
      c_sk    <= 1'b0;
      c_mm    <= 1'b0;
      c_dim   <= '0;
      c_ofs   <= '0;
      c_base  <= '0;
      c_mask  <= '0;
      c_ew    <= '0;
      c_mvl   <= '0;
      for (int s = 0; s < NSLOT; s++) slot_q[s] <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          d_q    <= '0;
          prod_q <= '0;
          c_idx  <= form_idx;
          c_yx   <= yx;
          c_sk   <= skip;
          c_mm   <= mm;
          c_dim  <= dim_m1;
          c_ofs  <= offset;
          c_base <= base;
          c_mask <= mask;
          c_ew   <= ew;
          c_mvl  <= maxvl;
        end
      end else if (more) begin
        d_q    <= d_q + 1'b1;
        prod_q <= prod_q + PW'(c_dim) + PW'(1);
      end else begin
        busy    <= 1'b0;
        done    <= 1'b1;
        persist <= c_mm;
        if (!c_mm) begin
          for (int s = 0; s < NSLOT; s++) slot_q[s] <= hit[s] ? shape : 32'd0;
          sel <= bsel;
          en  <= c_mask;
        end else begin
          slot_q[r_sl] <= shape;
          for (int k = 0; k < NOPS; k++) begin
            if (r_op == 3'(k)) begin
              sel[2*k +: 2] <= r_sl;
              en[k]         <= 1'b1;
            end
          end
        end
      end
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_out
    assign slots[32*s +: 32] = slot_q[s];
  end
endmodule

// File: rtl/shape_slot_alloc_checker.sv
module shape_slot_alloc_checker (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         mm,
  input logic         busy,
  input logic         done,
  input logic [127:0] slots,
  input logic [9:0]   sel,
  input logic [4:0]   en,
  input logic         persist
);
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ends_search_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_state_only_at_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(slots) && $stable(sel) && $stable(en)));

  p_persist_only_at_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(persist) |-> done);

  p_accept_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_mode_field_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (slots[31:30] == 2'b00 && slots[63:62] == 2'b00 &&
              slots[95:94] == 2'b00 && slots[127:126] == 2'b00));
endmodule

bind shape_slot_alloc shape_slot_alloc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mm(mm), .busy(busy), .done(done),
  .slots(slots), .sel(sel), .en(en), .persist(persist)
);

// File: tb/shape_slot_alloc_bench.sv
module shape_slot_alloc_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, form_idx = 1'b0, yx = 1'b0, skip = 1'b0, mm = 1'b0;
  logic [4:0] dim_m1 = '0, base = '0, mask = '0;
  logic [3:0] offset = '0;
  logic [1:0] ew = '0;
  logic [6:0] maxvl = '0;
  logic busy, done, persist;
  logic [127:0] slots;
  logic [9:0] sel;
  logic [4:0] en;

  int checks = 0, errors = 0;
  logic [31:0] m_slot [4];
  logic [9:0]  m_sel;
  logic [4:0]  m_en;
  logic        m_pers;

  always #10 clk = ~clk;

  shape_slot_alloc u_shape_slot_alloc (
    .clk(clk), .rst_n(rst_n), .start(start), .form_idx(form_idx), .dim_m1(dim_m1),
    .yx(yx), .skip(skip), .offset(offset), .base(base), .ew(ew), .mask(mask),
    .mm(mm), .maxvl(maxvl), .busy(busy), .done(done), .slots(slots), .sel(sel),
    .en(en), .persist(persist)
  );

  initial begin
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(string tag, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic int calc_d(int dm1, int mvl);
    int d = 0;
    while (d * (dm1 + 1) < mvl) d++;
    return d;
  endfunction

  function automatic logic [31:0] calc_shape(logic fi, logic y, logic sk, logic [4:0] dm1,
                                             logic [3:0] of, logic [4:0] b, logic [1:0] e, int d);
    logic [31:0] s = '0;
    s[5:0] = {1'b0, dm1};
    if (!y) s[11:6] = sk ? 6'd63 : 6'd0;
    else    s[11:6] = sk ? 6'd0 : 6'(d - 1);
    if (fi) begin
      s[20:18] = y ? 3'b111 : 3'b110;
      s[17:12] = {1'b0, b};
      s[21] = sk;
      s[29:28] = e;
    end else begin
      s[20:18] = y ? 3'b010 : 3'b000;
      s[27:24] = of;
      s[29:28] = sk ? 2'b01 : 2'b00;
    end
    return s;
  endfunction

  task automatic model_commit(logic [31:0] shp);
    if (!mm) begin
      int nxt = 0;
      for (int s = 0; s < 4; s++) m_slot[s] = '0;
      m_sel = '0;
      for (int k = 0; k < 5; k++) begin
        if (mask[k]) begin
          m_sel[2*k +: 2] = 2'(nxt);
          m_slot[nxt] = shp;
          nxt = (nxt + 1) % 4;
        end
      end
      m_en = mask;
    end else begin
      int p = mask[4:2];
      m_slot[mask[1:0]] = shp;
      if (p <= 4) begin
        m_sel[2*p +: 2] = mask[1:0];
        m_en[p] = 1'b1;
      end
    end
    m_pers = mm;
  endtask

  task automatic compare_all(string tag);
    chk({tag, " R8/R9 slot0"}, 128'(slots[31:0]),   128'(m_slot[0]));
    chk({tag, " R8/R9 slot1"}, 128'(slots[63:32]),  128'(m_slot[1]));
    chk({tag, " R8/R9 slot2"}, 128'(slots[95:64]),  128'(m_slot[2]));
    chk({tag, " R8/R9 slot3"}, 128'(slots[127:96]), 128'(m_slot[3]));
    chk({tag, " R8/R9 sel"}, 128'(sel), 128'(m_sel));
    chk({tag, " R8/R9 en"}, 128'(en), 128'(m_en));
    chk({tag, " R7 persist"}, 128'(persist), 128'(m_pers));
  endtask

  // Runs the command on the inputs; if inj_at >= 0 a second start with a
  // scrambled command is pulsed that many cycles into the search (R10).
  task automatic run_cmd(string tag, int inj_at);
    int d = calc_d(dim_m1, maxvl);
    logic [31:0] shp = calc_shape(form_idx, yx, skip, dim_m1, offset, base, ew, d);
    logic [4:0] sv_dim = dim_m1, sv_mask = mask;
    logic [6:0] sv_mvl = maxvl;
    logic sv_mm = mm;
    int cyc = 0;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 300) begin
      if (cyc == inj_at) begin
        start = 1'b1; dim_m1 = 5'd31; mask = 5'h1f; maxvl = 7'd1; mm = ~sv_mm;
      end
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    dim_m1 = sv_dim; mask = sv_mask; maxvl = sv_mvl; mm = sv_mm;
    chk({tag, " R2 latency"}, 128'(cyc), 128'(d + 1));
    model_commit(shp);
    compare_all(tag);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R2 done one cycle"}, 128'(done), 128'(0));
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int s = 0; s < 4; s++) m_slot[s] = '0;
    m_sel = '0; m_en = '0; m_pers = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset slots", slots, 128'd0);
    chk("R1 reset sel/en/persist", 128'({sel, en, persist}), 128'd0);
    chk("R1 reset busy/done", 128'({busy, done}), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // plain, yx=0, skip=1, bulk on operand 1 -> slot 0
    form_idx = 0; yx = 0; skip = 1; dim_m1 = 5'd3; offset = 4'hA; base = 5'd7; ew = 2'd2;
    mask = 5'b00010; mm = 0; maxvl = 7'd10;
    run_cmd("plain", -1);
    chk("R3 ydim yx0 skip", 128'(slots[11:6]), 128'(63));
    chk("R3 perm plain yx0", 128'(slots[20:18]), 128'(3'b000));
    chk("R5 offset", 128'(slots[27:24]), 128'(4'hA));
    chk("R5 skip field", 128'(slots[29:28]), 128'(2'b01));
    chk("R5 base/skipbit zero", 128'({slots[17:12], slots[21]}), 128'(0));

    // indexed, yx=1, skip=0 -> ydim = d-1; d = ceil(20/3) = 7
    form_idx = 1; yx = 1; skip = 0; dim_m1 = 5'd2; base = 5'd19; ew = 2'd3; offset = 4'hF;
    mask = 5'b00001; maxvl = 7'd20;
    run_cmd("indexed", -1);
    chk("R4 ydim d-1", 128'(slots[11:6]), 128'(6));
    chk("R4 perm idx yx1", 128'(slots[20:18]), 128'(3'b111));
    chk("R6 base", 128'(slots[17:12]), 128'(19));
    chk("R6 ew", 128'(slots[29:28]), 128'(3));
    chk("R6 offset zero", 128'(slots[27:24]), 128'(0));

    // maxvl = 0: d = 0, ydim wraps to 63
    maxvl = 7'd0;
    run_cmd("R4 zero maxvl", -1);
    chk("R4 ydim wrap", 128'(slots[11:6]), 128'(63));

    // all five operands: operand 4 wraps to slot 0
    form_idx = 0; mask = 5'h1f; maxvl = 7'd5;
    run_cmd("R8 wrap", -1);
    chk("R8 operand4 slot", 128'(sel[9:8]), 128'(0));
    chk("R8 operand3 slot", 128'(sel[7:6]), 128'(3));

    // refined, operand 6 (out of range), slot 2
    mm = 1; mask = {3'd6, 2'd2}; dim_m1 = 5'd9;
    run_cmd("R9 op6", -1);
    chk("R9 op6 sel kept", 128'(sel), 128'(10'b00_11_10_01_00));
    // refined, operand 4 to slot 3
    mask = {3'd4, 2'd3}; yx = 0; skip = 0;
    run_cmd("R9 op4", -1);

    // start during busy ignored
    mm = 0; dim_m1 = 5'd0; maxvl = 7'd100; mask = 5'b00100;
    run_cmd("R10 busy start", 3);

    for (int n = 0; n < 150; n++) begin
      form_idx = 1'($urandom); yx = 1'($urandom); skip = 1'($urandom);
      dim_m1 = 5'($urandom); offset = 4'($urandom); base = 5'($urandom);
      ew = 2'($urandom); mask = 5'($urandom); mm = 1'($urandom);
      maxvl = 7'($urandom);
      run_cmd("random R3/R4/R5/R6", ($urandom % 4 == 0) ? 1 : -1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule